// File: doc/BRIEF.md
# Eight-Function Microoperation Register

This block is a single register of parameterised width whose next value is chosen, once per clock, from a fixed menu of eight microoperations. A 3-bit operation code selects the operation. The menu holds a parallel load from a data input, a bitwise inversion, and three shift styles (logical, circular and arithmetic), each in both directions. Every bit has its own 8-way multiplexer that the operation code steers, and all bits are written on the same clock edge.

An enable input decides whether the selected operation takes effect on a given edge. When enable is low, the register keeps its contents whatever the operation code is. A synchronous active-high reset clears the register and overrides every other input. The block suits a datapath that needs one working register able to do single-step manipulations under control of a sequencer.

Top module: `uop_shift_reg`

## Requirements
- R1: When `rst` is high at a rising clock edge, every bit of `q` becomes 0, even if `en` is high and any `op` is presented.
- R2: When `rst` is low and `en` is low at a rising edge, `q` keeps its value for every `op` code.
- R3: Code 0 (3'b000) with `en` high copies `d` into `q`.
- R4: Code 1 (3'b001) with `en` high replaces every bit of `q` with its inverse.
- R5: Code 2 (3'b010) shifts left logically. Bit i takes old bit i-1, bit 0 takes 0, and the old top bit is dropped.
- R6: Code 3 (3'b011) shifts right logically. Bit i takes old bit i+1, the top bit takes 0, and the old bit 0 is dropped.
- R7: Code 4 (3'b100) rotates left. Bit i takes old bit (i-1) mod WIDTH, so the old top bit moves into bit 0.
- R8: Code 5 (3'b101) rotates right. Bit i takes old bit (i+1) mod WIDTH, so the old bit 0 moves into the top bit; for WIDTH=5, old bit 0 lands in bit 4.
- R9: Code 6 (3'b110) shifts left arithmetically. The result is the same as code 2: 0 enters bit 0 and the top bit is lost.
- R10: Code 7 (3'b111) shifts right arithmetically. The top bit keeps its value, each lower bit takes the bit above it, and the old bit 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bits update on its rising edge |
| rst | input | 1 | Synchronous active-high clear, overrides enable |
| en | input | 1 | Applies the selected operation when high |
| op | input | 3 | Operation code, 0 to 7 |
| d | input | WIDTH | Parallel data for the load operation |
| q | output | WIDTH | Current register contents |

## Verification
Reset and an enabled operation can coincide on one edge. The bench holds `rst` high while `en` is high with a load of all ones, and later with a complement of a non-zero value. It judges reset the winner only if `q` reads zero one edge later. The bench also pairs a low enable with every operation code in turn, from a pattern that each code would change. After each edge `q` must equal the prior value, which shows that select alone never writes the register.

// File: rtl/uop_pkg.sv
package uop_pkg;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_INV  = 3'd1,
        OP_SHL  = 3'd2,
        OP_SHR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_ASL  = 3'd6,
        OP_ASR  = 3'd7
    } op_t;

    localparam int unsigned N_OPS = 8;

endpackage

// File: rtl/uop_bit_mux.sv
module uop_bit_mux
    import uop_pkg::*;
#(
    parameter int unsigned N_IN = N_OPS,
    localparam int unsigned SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  cand,
    input  logic [SEL_W-1:0] sel,
    output logic             pick
);

    always_comb begin
        pick = cand[sel];
    end

endmodule

// File: rtl/uop_next_net.sv
module uop_next_net
    import uop_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  op_t              op,
    output logic [WIDTH-1:0] nxt
);

    localparam int unsigned TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // neighbour indices with wrap-around for the circular cases
        localparam int unsigned BELOW = (i == 0)   ? TOP : i - 1;
        localparam int unsigned ABOVE = (i == TOP) ? 0   : i + 1;

        logic [N_OPS-1:0] cand;
        logic             from_below_fill0;
        logic             from_above_fill0;
        logic             from_above_sign;

        if (i == 0) begin : g_lsb
            assign from_below_fill0 = 1'b0;
        end else begin : g_mid_lo
            assign from_below_fill0 = cur[BELOW];
        end

        if (i == TOP) begin : g_msb
            assign from_above_fill0 = 1'b0;
            assign from_above_sign  = cur[TOP];
        end else begin : g_mid_hi
            assign from_above_fill0 = cur[ABOVE];
            assign from_above_sign  = cur[ABOVE];
        end

        always_comb begin
            cand            = '0;
            cand[OP_LOAD]   = din[i];
            cand[OP_INV]    = ~cur[i];
            cand[OP_SHL]    = from_below_fill0;
            cand[OP_SHR]    = from_above_fill0;
            cand[OP_ROL]    = cur[BELOW];
            cand[OP_ROR]    = cur[ABOVE];
            cand[OP_ASL]    = from_below_fill0;
            cand[OP_ASR]    = from_above_sign;
        end

        uop_bit_mux #(
            .N_IN (N_OPS)
        ) u_mux (
            .cand (cand),
            .sel  (op),
            .pick (nxt[i])
        );
    end

endmodule

// File: rtl/uop_shift_reg.sv
module uop_shift_reg
    import uop_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [WIDTH-1:0] op_result;
    op_t              op_sel;

    assign op_sel = op_t'(op);

    uop_next_net #(
        .WIDTH (WIDTH)
    ) u_net (
        .cur (st_q.val),
        .din (d),
        .op  (op_sel),
        .nxt (op_result)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = '0;
        end else if (en) begin
            st_d.val = op_result;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

    // R3
    load_copies_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_LOAD) |=> (q == $past(d)));

    // R4
    invert_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_INV) |=> (q == ~$past(q)));

    // R5
    shl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_SHL) |=> (q[0] == 1'b0));

    // R6
    shr_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_SHR) |=> (q[WIDTH-1] == 1'b0));

    // R7
    rol_keeps_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_ROL) |=> ($countones(q) == $countones($past(q))));

    // R8
    ror_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_ROR) |=> (q[WIDTH-1] == $past(q[0])));

    // R9
    asl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_ASL) |=> (q[0] == 1'b0));

    // R10
    asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == OP_ASR) |=> (q[WIDTH-1] == $past(q[WIDTH-1])));

endmodule

// File: tb/uop_shift_reg_tb.sv
module uop_shift_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int W5         = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [2:0]    op  = 3'd0;
    logic [W-1:0]  d   = '0;
    logic [W-1:0]  q;
    logic [W5-1:0] d5  = '0;
    logic [W5-1:0] q5;

    int n_checks = 0;
    int n_fails  = 0;
    logic [W-1:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uop_shift_reg #(.WIDTH(W)) u_dut (
        .clk (clk), .rst (rst), .en (en), .op (op), .d (d), .q (q)
    );

    uop_shift_reg #(.WIDTH(W5)) u_dut5 (
        .clk (clk), .rst (rst), .en (en), .op (op), .d (d5), .q (q5)
    );

    function automatic logic [W-1:0] ref_next(input logic [2:0] c,
                                              input logic [W-1:0] cur,
                                              input logic [W-1:0] din);
        case (c)
            3'd0: ref_next = din;
            3'd1: ref_next = ~cur;
            3'd2: ref_next = {cur[W-2:0], 1'b0};
            3'd3: ref_next = {1'b0, cur[W-1:1]};
            3'd4: ref_next = {cur[W-2:0], cur[W-1]};
            3'd5: ref_next = {cur[0], cur[W-1:1]};
            3'd6: ref_next = {cur[W-2:0], 1'b0};
            default: ref_next = {cur[W-1], cur[W-1:1]};
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive after the falling edge, sample 1 time unit past the rising edge
    task automatic step(input logic r, input logic e, input logic [2:0] c,
                        input logic [W-1:0] din);
        @(negedge clk);
        rst = r; en = e; op = c; d = din;
        @(posedge clk);
        #1;
    endtask

    task automatic load_val(input logic [W-1:0] v);
        step(1'b0, 1'b1, 3'd0, v);
        model = v;
    endtask

    task automatic t_reset_state;
        step(1'b1, 1'b1, 3'd0, 8'hFF);
        step(1'b1, 1'b1, 3'd0, 8'hFF);
        model = '0;
        check("R1 reset with enable+load", q, 8'h00);
    endtask

    task automatic t_reset_over_op;
        load_val(8'h5A);
        step(1'b1, 1'b1, 3'd1, 8'h00);
        model = '0;
        check("R1 reset beats complement", q, 8'h00);
    endtask

    task automatic t_hold_all_codes;
        load_val(8'hA5);
        for (int c = 0; c < 8; c++) begin
            step(1'b0, 1'b0, c[2:0], 8'h3C);
            check("R2 hold with enable low", q, 8'hA5);
        end
    endtask

    task automatic t_single(input string req, input logic [2:0] c,
                            input logic [W-1:0] start,
                            input logic [W-1:0] din);
        logic [W-1:0] exp;
        load_val(start);
        exp = ref_next(c, model, din);
        step(1'b0, 1'b1, c, din);
        model = exp;
        check(req, q, exp);
    endtask

    task automatic t_load;
        t_single("R3 load", 3'd0, 8'h00, 8'hC3);
        t_single("R3 load", 3'd0, 8'hFF, 8'h01);
    endtask

    task automatic t_invert;
        t_single("R4 complement", 3'd1, 8'h96, 8'h00);
        t_single("R4 complement", 3'd1, 8'h00, 8'hFF);
    endtask

    task automatic t_shl;
        t_single("R5 logical left", 3'd2, 8'h81, 8'h00);
        t_single("R5 logical left", 3'd2, 8'h7F, 8'h00);
    endtask

    task automatic t_shr;
        t_single("R6 logical right", 3'd3, 8'h81, 8'h00);
        t_single("R6 logical right", 3'd3, 8'hFE, 8'h00);
    endtask

    task automatic t_rol;
        t_single("R7 rotate left", 3'd4, 8'h81, 8'h00);
        t_single("R7 rotate left", 3'd4, 8'h40, 8'h00);
    endtask

    task automatic t_ror;
        t_single("R8 rotate right", 3'd5, 8'h81, 8'h00);
        t_single("R8 rotate right", 3'd5, 8'h02, 8'h00);
    endtask

    task automatic t_asl;
        t_single("R9 arithmetic left", 3'd6, 8'hC1, 8'h00);
        t_single("R9 arithmetic left", 3'd6, 8'h55, 8'h00);
    endtask

    task automatic t_asr;
        t_single("R10 arithmetic right", 3'd7, 8'h81, 8'h00);
        t_single("R10 arithmetic right", 3'd7, 8'h42, 8'h00);
        // repeated sign replication from a negative value
        load_val(8'h80);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1, 3'd7, 8'h00);
        end
        check("R10 arithmetic right x3", q, 8'hF0);
    endtask

    task automatic t_ror_width5;
        logic [W-1:0] act;
        logic [W-1:0] exp;
        @(negedge clk);
        rst = 1'b0; en = 1'b1; op = 3'd0; d5 = 5'b10110;
        @(posedge clk);
        #1;
        step(1'b0, 1'b1, 3'd5, 8'h00);
        act = {3'b000, q5};
        exp = 8'b0000_1011;
        check("R8 width5 rotate right", act, exp);
        step(1'b0, 1'b1, 3'd5, 8'h00);
        act = {3'b000, q5};
        exp = 8'b0001_0101;
        check("R8 width5 bit0 into bit4", act, exp);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_hold_all_codes();
        t_load();
        t_invert();
        t_shl();
        t_shr();
        t_rol();
        t_ror();
        t_asl();
        t_asr();
        t_ror_width5();
        t_reset_over_op();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule